// File: doc/BRIEF.md
# Sixteen-Bit Pair Arithmetic Unit With Flags

This block performs sixteen-bit arithmetic on a register-pair value for a small processor datapath. It handles three operations: a plain add, an add that also takes in the incoming carry, and a subtract that also takes away the incoming carry. The caller supplies the destination pair value, the source value, the current flag byte and a two-bit operation code. The block returns the sixteen-bit result together with a new flag byte.

Results are captured in a register stage. Raising `in_valid` for one cycle loads the result and flags on the next rising clock edge, and `out_valid` is high for exactly that one following cycle. Between loads the outputs hold their last value. The plain add changes only the carry, half-carry and subtract indications and keeps the other condition bits from the caller. The two carry-aware operations rebuild every flag from the full sixteen-bit result.

Flag byte layout (bit positions are fixed because downstream logic decodes them): bit 7 sign, bit 6 zero, bit 5 always 0, bit 4 half-carry, bit 3 always 0, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Operation codes: 00 plain add, 01 add with carry, 10 subtract with carry, 11 pass-through.

Top module: `pair_alu16`

## Requirements
- R1: With op 00 the result is (dest + src) mod 65536. Carry (bit 0) is bit 16 of the sum. Subtract (bit 1) is 0.
- R2: With op 00 the sign (bit 7), zero (bit 6) and parity/overflow (bit 2) outputs equal the incoming flag bits.
- R3: With op 01 the result is (dest + src + incoming carry bit 0) mod 65536. Carry is bit 16 of that sum. Subtract is 0.
- R4: With op 01 or op 10, zero is 1 exactly when the sixteen-bit result is 0x0000, and sign equals result bit 15.
- R5: With op 01, overflow (bit 2) is 1 exactly when dest and src agree in bit 15 and result bit 15 differs from them.
- R6: With op 10 the result is (dest - src - incoming carry) mod 65536. Carry is 1 on a borrow (dest < src + carry). Subtract is 1.
- R7: With op 10, overflow is 1 exactly when dest and src differ in bit 15 and result bit 15 differs from dest bit 15.
- R8: For ops 00, 01 and 10, half-carry (bit 4) is the carry out of bit 11 for the adds and the borrow out of bit 11 for the subtract, with the incoming carry included where the operation uses it.
- R9: Flag bits 5 and 3 of the output are always 0 after a load.
- R10: With op 11 the result equals dest and the flags equal the incoming flags with bits 5 and 3 cleared.
- R11: Result and flags update on the first rising edge after a cycle with `in_valid` high. `out_valid` is high for exactly the next cycle. Without `in_valid` the outputs hold.
- R12: While reset is asserted, `out_valid`, `result` and `flags_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Load strobe for the operands |
| op_sel | input | 2 | Operation code (00 add, 01 add with carry, 10 subtract with carry, 11 pass) |
| dest_val | input | 16 | Destination pair value |
| src_val | input | 16 | Source operand |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 16 | Registered sixteen-bit result |
| flags_out | output | 8 | Registered updated flag byte |

## Verification
Random operands and random incoming flag bytes are applied to all four operation codes. For the plain add, random incoming flag bytes separate kept bits from rewritten bits. Directed operands target the edges:
- 0xFFFF plus 1 and 0x0FFF plus 1 separate carry out of bit 15 from carry out of bit 11.
- 0x7FFF plus a carry and 0x8000 minus 1 produce signed overflow in each direction.
- Zero minus zero with a borrow in, and equal operands, separate borrow from zero.

Idle cycles with changing inputs show that the registered outputs hold between loads.

// File: rtl/pair_alu16_pkg.sv
package pair_alu16_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_ADC  = 2'b01,
    OP_SBC  = 2'b10,
    OP_PASS = 2'b11
  } alu_op_e;

  localparam int FLAG_W = 8;
  localparam int FB_C   = 0;
  localparam int FB_N   = 1;
  localparam int FB_PV  = 2;
  localparam int FB_X3  = 3;
  localparam int FB_H   = 4;
  localparam int FB_X5  = 5;
  localparam int FB_Z   = 6;
  localparam int FB_S   = 7;

endpackage

// File: rtl/pair_alu16_rst_sync.sv
module pair_alu16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pair_alu16_core.sv
module pair_alu16_core
  import pair_alu16_pkg::*;
#(
  parameter int W  = 16,
  parameter int HB = 11
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] b_val,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         half_out,
  output logic         ovf_out
);

  localparam int LO_W = HB + 1;

  logic         is_sub;
  logic         use_c;
  logic         ci;
  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic [LO_W:0] low;

  always_comb begin
    is_sub = (op == OP_SBC);
    use_c  = (op == OP_ADC) || (op == OP_SBC);
    b_eff  = is_sub ? ~b_val : b_val;
    ci     = is_sub ? ~(use_c & carry_in) : (use_c & carry_in);
    full   = {1'b0, a_val} + {1'b0, b_eff} + {{W{1'b0}}, ci};
    low    = {1'b0, a_val[HB:0]} + {1'b0, b_eff[HB:0]} + {{LO_W{1'b0}}, ci};
    sum       = full[W-1:0];
    carry_out = full[W] ^ is_sub;
    half_out  = low[LO_W] ^ is_sub;
    ovf_out   = (a_val[W-1] == b_eff[W-1]) && (full[W-1] != a_val[W-1]);
  end

endmodule

// File: rtl/pair_alu16_flags.sv
module pair_alu16_flags
  import pair_alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e           op,
  input  logic [W-1:0]      a_val,
  input  logic [W-1:0]      sum,
  input  logic              carry,
  input  logic              half,
  input  logic              ovf,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [W-1:0]      res_nxt,
  output logic [FLAG_W-1:0] flags_nxt
);

  always_comb begin
    res_nxt   = sum;
    flags_nxt = '0;
    unique case (op)
      OP_ADD: begin
        flags_nxt        = flags_in;
        flags_nxt[FB_C]  = carry;
        flags_nxt[FB_N]  = 1'b0;
        flags_nxt[FB_H]  = half;
        flags_nxt[FB_X3] = 1'b0;
        flags_nxt[FB_X5] = 1'b0;
      end
      OP_ADC, OP_SBC: begin
        flags_nxt[FB_S]  = sum[W-1];
        flags_nxt[FB_Z]  = (sum == '0);
        flags_nxt[FB_H]  = half;
        flags_nxt[FB_PV] = ovf;
        flags_nxt[FB_N]  = (op == OP_SBC);
        flags_nxt[FB_C]  = carry;
      end
      OP_PASS: begin
        res_nxt          = a_val;
        flags_nxt        = flags_in;
        flags_nxt[FB_X3] = 1'b0;
        flags_nxt[FB_X5] = 1'b0;
      end
      default: begin
        res_nxt   = sum;
        flags_nxt = '0;
      end
    endcase
  end

endmodule

// File: rtl/pair_alu16_oreg.sv
module pair_alu16_oreg #(
  parameter int W  = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  res_d,
  input  logic [FW-1:0] flg_d,
  output logic          valid_q,
  output logic [W-1:0]  res_q,
  output logic [FW-1:0] flg_q
);

  logic          valid_n;
  logic [W-1:0]  res_n;
  logic [FW-1:0] flg_n;

  always_comb begin
    valid_n = load;
    res_n   = res_q;
    flg_n   = flg_q;
    if (load) begin
      res_n = res_d;
      flg_n = flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_n;
      res_q   <= res_n;
      flg_q   <= flg_n;
    end
  end

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid_q);

  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !valid_q);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(res_q) && $stable(flg_q)));

  // R11
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (res_q == $past(res_d)));

endmodule

// File: rtl/pair_alu16.sv
module pair_alu16
  import pair_alu16_pkg::*;
#(
  parameter int W       = 16,
  parameter int HALF_B  = 11,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [W-1:0]      dest_val,
  input  logic [W-1:0]      src_val,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags_out
);

  logic              rst_sync_n;
  alu_op_e           op;
  logic [W-1:0]      sum;
  logic              carry;
  logic              half;
  logic              ovf;
  logic [W-1:0]      res_nxt;
  logic [FLAG_W-1:0] flg_nxt;

  assign op = alu_op_e'(op_sel);

  pair_alu16_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pair_alu16_core #(.W(W), .HB(HALF_B)) u_core (
    .op        (op),
    .a_val     (dest_val),
    .b_val     (src_val),
    .carry_in  (flags_in[FB_C]),
    .sum       (sum),
    .carry_out (carry),
    .half_out  (half),
    .ovf_out   (ovf)
  );

  pair_alu16_flags #(.W(W)) u_flags (
    .op        (op),
    .a_val     (dest_val),
    .sum       (sum),
    .carry     (carry),
    .half      (half),
    .ovf       (ovf),
    .flags_in  (flags_in),
    .res_nxt   (res_nxt),
    .flags_nxt (flg_nxt)
  );

  pair_alu16_oreg #(.W(W), .FW(FLAG_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (in_valid),
    .res_d   (res_nxt),
    .flg_d   (flg_nxt),
    .valid_q (out_valid),
    .res_q   (result),
    .flg_q   (flags_out)
  );

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (op == OP_ADC || op == OP_SBC)) |-> (flg_nxt[FB_Z] == (sum == '0)));

  // R2
  keep_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_ADD) |=>
      (flags_out[FB_S] == $past(flags_in[FB_S]) && flags_out[FB_Z] == $past(flags_in[FB_Z])
       && flags_out[FB_PV] == $past(flags_in[FB_PV])));

  // R6
  sub_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_SBC) |=> flags_out[FB_N]);

  // R9
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (!flags_out[FB_X5] && !flags_out[FB_X3]));

  // R10
  pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_PASS) |=> (result == $past(dest_val)));

endmodule

// File: tb/pair_alu16_bench.sv
module pair_alu16_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic [15:0] dest_val;
  logic [15:0] src_val;
  logic [7:0]  flags_in;
  logic        out_valid;
  logic [15:0] result;
  logic [7:0]  flags_out;

  int n_checks;
  int n_fail;
  bit done;

  pair_alu16 u_pair_alu16 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .dest_val  (dest_val),
    .src_val   (src_val),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [23:0] model(input logic [1:0] op, input logic [15:0] d,
                                        input logic [15:0] s, input logic [7:0] fi);
    int t;
    int cin;
    logic [15:0] r;
    logic [7:0]  f;
    cin = int'(fi[0]);
    f = 8'h00;
    r = d;
    case (op)
      2'b00: begin
        t = int'(d) + int'(s);
        r = t[15:0];
        f = fi & 8'hC4;
        f[4] = ((int'(d) & 4095) + (int'(s) & 4095)) > 4095;
        f[0] = t > 65535;
      end
      2'b01: begin
        t = int'(d) + int'(s) + cin;
        r = t[15:0];
        f[7] = r[15];
        f[6] = (r == 16'h0000);
        f[4] = ((int'(d) & 4095) + (int'(s) & 4095) + cin) > 4095;
        f[2] = (d[15] == s[15]) && (r[15] != d[15]);
        f[0] = t > 65535;
      end
      2'b10: begin
        t = int'(d) - int'(s) - cin;
        r = t[15:0];
        f[7] = r[15];
        f[6] = (r == 16'h0000);
        f[4] = (int'(d) & 4095) < ((int'(s) & 4095) + cin);
        f[2] = (d[15] != s[15]) && (r[15] != d[15]);
        f[1] = 1'b1;
        f[0] = t < 0;
      end
      default: begin
        r = d;
        f = fi & 8'hD7;
      end
    endcase
    return {r, f};
  endfunction

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'b00:   return "R1 R2 R8 R9";
      2'b01:   return "R3 R4 R5 R8";
      2'b10:   return "R6 R4 R7 R8";
      default: return "R10 R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] d,
                        input logic [15:0] s, input logic [7:0] fi);
    logic [23:0] e;
    e = model(op, d, s, fi);
    op_sel   = op;
    dest_val = d;
    src_val  = s;
    flags_in = fi;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({"R11 valid ", tag_of(op)}, 32'(out_valid), 32'd1);
    check({"result ", tag_of(op)}, 32'(result), 32'(e[23:8]));
    check({"flags ", tag_of(op)}, 32'(flags_out), 32'(e[7:0]));
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] hr;
    logic [7:0]  hf;
    int seed;
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op_sel   = 2'b00;
    dest_val = 16'h1234;
    src_val  = 16'h4321;
    flags_in = 8'hFF;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 out_valid", 32'(out_valid), 32'd0);
    check("R12 result", 32'(result), 32'd0);
    check("R12 flags", 32'(flags_out), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    run_op(2'b00, 16'hFFFF, 16'h0001, 8'hFF);   // R1 carry out, R2 kept, R9
    run_op(2'b00, 16'h0FFF, 16'h0001, 8'h00);   // R8 half carry
    run_op(2'b01, 16'h7FFF, 16'h0000, 8'h01);   // R5 overflow
    run_op(2'b01, 16'hFFFF, 16'h0000, 8'h01);   // R4 zero with carry
    run_op(2'b10, 16'h0000, 16'h0000, 8'h01);   // R6 borrow
    run_op(2'b10, 16'h8000, 16'h0001, 8'h00);   // R7 overflow
    run_op(2'b10, 16'hA5A5, 16'hA5A5, 8'h00);   // R4 zero
    run_op(2'b11, 16'hBEEF, 16'h1111, 8'hFF);   // R10 pass

    // R11 hold with changing inputs and no strobe
    hr = result;
    hf = flags_out;
    for (int i = 0; i < 4; i++) begin
      op_sel   = 2'(i);
      dest_val = 16'(i * 16'h1357);
      src_val  = 16'(i * 16'h0F0F);
      flags_in = 8'(i * 8'h35);
      @(negedge clk);
      check("R11 no pulse", 32'(out_valid), 32'd0);
      check("R11 hold result", 32'(result), 32'(hr));
      check("R11 hold flags", 32'(flags_out), 32'(hf));
    end

    // random mix, including back-to-back strobes
    for (int i = 0; i < 400; i++) begin
      run_op(2'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
      if (($urandom % 3) == 0) @(negedge clk);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule